// File: doc/BRIEF.md
# Configurable-Accuracy OR-Approximated Adder

This block is a combinational 16-bit adder whose accuracy is chosen at run time. The sum is built from four 4-bit chunks. The most significant chunk is always a true adder. The three chunks below it can each run in one of two ways. In the cheap way, a chunk outputs the bitwise OR of its operand bits, creates no carry and passes a carry of zero upward. In the other way, the chunk is a short exact sub-adder that joins the exact carry chain.

A 2-bit stage count sets how many of the lower chunks are corrected. Correction starts at the chunk next to the exact top chunk and moves down. The exact region is therefore always one contiguous adder that runs from the most significant bit down to a chunk boundary. Below that boundary, every bit is plain OR.

There is no error detection and no recovery step. The stage count alone sets the quality of the result. A count of three makes the block an exact adder. Error-tolerant datapaths can lower the count to save switching energy where a small loss of precision is acceptable.

Top module: `or_approx_adder`

## Requirements
- R1: With stage count 3, {carry_out, sum_out} equals the full 17-bit value A + B for every pair of operands.
- R2: With stage count 0, sum_out bits 11..0 equal A | B on those bits.
- R3: With stage count 0, {carry_out, sum_out[15:12]} equals A[15:12] + B[15:12], with no carry coming from below bit 12.
- R4: With stage count 1, sum_out[7:0] equals (A | B)[7:0], and {carry_out, sum_out[15:8]} equals A[15:8] + B[15:8].
- R5: With stage count 2, sum_out[3:0] equals (A | B)[3:0], and {carry_out, sum_out[15:4]} equals A[15:4] + B[15:4].
- R6: For every stage count, the 17-bit value {carry_out, sum_out} is never larger than A + B.
- R7: When A & B is zero on bits 11..0, the result equals A + B exactly for every stage count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| stages | input | 2 | Number of corrected chunks, counted downward from the exact top chunk (0..3) |
| sum_out | output | 16 | Sum, exact above the correction boundary and OR below it |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
The bench targets carries that try to cross the correction boundary. An example is 0x0FFF + 0x0001 at stage count 0. A design that let the OR chunk emit a carry would put a 1 at bit 12 instead of leaving the upper chunk untouched. All-ones operands at full correction check the carry out of bit 15. A design that dropped carry_out, or that left one chunk approximate, would return a value short of 0x1FFFE. Operands with no overlapping bits in the low 12 positions must come out exact at every count. A wrong chunk-enable order, for example one that corrects from the bottom up, shows up at counts 1 and 2 as OR bits appearing in the wrong chunk.

// File: rtl/orad_pkg.sv
package orad_pkg;
    localparam int ORAD_WIDTH = 16;
    localparam int ORAD_CHUNK = 4;

    // Number of chunks below the top that can be approximated
    function automatic int apx_chunks(input int width, input int chunk);
        return (width / chunk) - 1;
    endfunction

    // Chunk idx (0 = least significant) is corrected when the count reaches it
    function automatic logic chunk_is_exact(input int idx, input int napx, input int count);
        return (idx >= napx) || (count >= (napx - idx));
    endfunction

    typedef enum logic [0:0] {
        CH_APPROX = 1'b0,
        CH_EXACT  = 1'b1
    } chunk_mode_e;
endpackage

// File: rtl/orad_exact_chunk.sv
module orad_exact_chunk #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] total;

    always_comb begin
        total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        sum   = total[W-1:0];
        cout  = total[W];
    end
endmodule

// File: rtl/orad_or_chunk.sv
module orad_or_chunk #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    always_comb sum = a | b;
endmodule

// File: rtl/orad_stage_dec.sv
module orad_stage_dec
    import orad_pkg::*;
#(
    parameter int NAPX  = 3,
    parameter int STG_W = 2
) (
    input  logic [STG_W-1:0] stages,
    output chunk_mode_e      mode [NAPX]
);
    for (genvar i = 0; i < NAPX; i++) begin : g_dec
        always_comb
            mode[i] = chunk_is_exact(i, NAPX, int'(stages)) ? CH_EXACT : CH_APPROX;
    end
endmodule

// File: rtl/or_approx_adder.sv
module or_approx_adder
    import orad_pkg::*;
#(
    parameter int WIDTH = ORAD_WIDTH,
    parameter int CHUNK = ORAD_CHUNK,
    localparam int NCHUNK = WIDTH / CHUNK,
    localparam int NAPX   = NCHUNK - 1,
    localparam int STG_W  = $clog2(NAPX + 1)
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [STG_W-1:0] stages,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);
    chunk_mode_e       mode [NAPX];
    logic [NCHUNK-1:0] ch_carry;

    orad_stage_dec #(.NAPX(NAPX), .STG_W(STG_W)) u_dec (
        .stages (stages),
        .mode   (mode)
    );

    for (genvar i = 0; i < NCHUNK; i++) begin : g_chunk
        localparam int LO = i * CHUNK;
        logic             cin_w;
        logic [CHUNK-1:0] ex_sum;
        logic             ex_cout;

        if (i == 0) begin : g_cin0
            assign cin_w = 1'b0;
        end else begin : g_cinn
            assign cin_w = ch_carry[i-1];
        end

        orad_exact_chunk #(.W(CHUNK)) u_exact (
            .a    (a_in[LO +: CHUNK]),
            .b    (b_in[LO +: CHUNK]),
            .cin  (cin_w),
            .sum  (ex_sum),
            .cout (ex_cout)
        );

        if (i == NCHUNK - 1) begin : g_top
            assign sum_out[LO +: CHUNK] = ex_sum;
            assign ch_carry[i]          = ex_cout;
        end else begin : g_low
            logic [CHUNK-1:0] or_sum;
            orad_or_chunk #(.W(CHUNK)) u_or (
                .a   (a_in[LO +: CHUNK]),
                .b   (b_in[LO +: CHUNK]),
                .sum (or_sum)
            );
            // An approximate chunk emits no carry upward
            assign sum_out[LO +: CHUNK] = (mode[i] == CH_EXACT) ? ex_sum : or_sum;
            assign ch_carry[i]          = (mode[i] == CH_EXACT) ? ex_cout : 1'b0;
        end
    end

    assign carry_out = ch_carry[NCHUNK-1];
endmodule

// File: rtl/or_approx_adder_chk.sv
module or_approx_adder_chk #(
    parameter int WIDTH = 16,
    parameter int CHUNK = 4,
    localparam int NAPX  = WIDTH / CHUNK - 1,
    localparam int STG_W = $clog2(NAPX + 1),
    localparam int APXB  = NAPX * CHUNK
) (
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [STG_W-1:0] stages,
    input logic [WIDTH-1:0] sum_out,
    input logic             carry_out
);
    logic [WIDTH:0] full;
    logic [WIDTH:0] got;
    logic [WIDTH:0] top_ref;
    logic [WIDTH:0] top_got;
    int             cut;

    always_comb begin
        full    = {1'b0, a_in} + {1'b0, b_in};
        got     = {carry_out, sum_out};
        cut     = CHUNK * (NAPX - int'(stages));
        top_ref = ({1'b0, a_in} >> cut) + ({1'b0, b_in} >> cut);
        top_got = got >> cut;

        // R1
        exact_full_chk: assert (int'(stages) != NAPX || got == full);
        // R2
        low_or_chk: assert (stages != '0 || sum_out[APXB-1:0] == (a_in[APXB-1:0] | b_in[APXB-1:0]));
        // R3 R4 R5
        upper_exact_chk: assert (int'(stages) > NAPX || top_got == top_ref);
        // R6
        no_overshoot_chk: assert (got <= full);
        // R7
        disjoint_exact_chk: assert (((a_in & b_in) & {{(WIDTH-APXB){1'b0}}, {APXB{1'b1}}}) != '0 || got == full);
    end
endmodule

bind or_approx_adder or_approx_adder_chk #(.WIDTH(WIDTH), .CHUNK(CHUNK)) u_chk (
    .a_in      (a_in),
    .b_in      (b_in),
    .stages    (stages),
    .sum_out   (sum_out),
    .carry_out (carry_out)
);

// File: tb/or_approx_adder_bench.sv
module or_approx_adder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a_in = '0;
    logic [15:0] b_in = '0;
    logic [1:0]  stages = '0;
    logic [15:0] sum_out;
    logic        carry_out;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    or_approx_adder u_or_approx_adder (
        .a_in      (a_in),
        .b_in      (b_in),
        .stages    (stages),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    // Behavioural reference: low bits below the boundary are OR, the rest a true sum
    function automatic int model(input int a, input int b, input int s);
        int w;
        int lo;
        int hi;
        w  = 4 * (3 - s);
        lo = (a | b) & ((1 << w) - 1);
        hi = ((a >> w) + (b >> w)) << w;
        return (hi | lo) & 32'h1FFFF;
    endfunction

    task automatic apply(input string tag, input int a, input int b, input int s);
        int act;
        int exp;
        @(negedge clk);
        a_in   = 16'(a);
        b_in   = 16'(b);
        stages = 2'(s);
        @(posedge clk);
        #1;
        act = int'({carry_out, sum_out});
        exp = model(a, b, s);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s a=%h b=%h s=%0d actual=%h expected=%h", tag, a, b, s, act, exp);
        end
        // R6: never above the true sum
        n_cmp++;
        if (act > a + b) begin
            n_bad++;
            $display("FAIL R6 a=%h b=%h s=%0d actual=%h expected<=%h", a, b, s, act, a + b);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset-time state: zero operands give zero
        apply("R2", 0, 0, 0);
        // R3: low carry must not reach bit 12
        apply("R3", 16'h0FFF, 16'h0001, 0);
        apply("R3", 16'hF800, 16'h0800, 0);
        // R1: full carry out
        apply("R1", 16'hFFFF, 16'hFFFF, 3);
        apply("R1", 16'hFFFF, 16'h0001, 3);
        apply("R1", 16'h0FFF, 16'h0001, 3);
        // R4 / R5 boundary carries
        apply("R4", 16'h00FF, 16'h0001, 1);
        apply("R4", 16'h0F0F, 16'h0101, 1);
        apply("R5", 16'h000F, 16'h0001, 2);
        apply("R5", 16'h00F0, 16'h0010, 2);
        // R7: disjoint low bits exact at every count
        for (int s = 0; s < 4; s++) apply("R7", 16'hFA50, 16'h05AF, s);
        for (int k = 0; k < 200; k++) begin
            int a;
            int b;
            a = int'($urandom_range(0, 16'hFFFF));
            b = int'($urandom_range(0, 16'hFFFF));
            apply("R1", a, b, 3);
            apply("R2", a, b, 0);
            apply("R4", a, b, 1);
            apply("R5", a, b, 2);
            b = b & ~(a & 16'h0FFF);
            apply("R7", a, b, k % 4);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule